// File: doc/BRIEF.md
# SPI EEPROM Read Sequencer

This block is the read path of a small serial memory slave that holds 512 bytes in registers. It follows chip select, serial clock and serial data in. The instruction byte carries the ninth address bit, and an address byte follows it. After that header the block streams stored bytes out, most significant bit first, for as long as the host keeps clocking.

The block works in SPI mode 0. It captures input bits on rising serial clock edges and presents output bits on falling edges. The output pin is meant to be driven by an external tri-state buffer, under the control of the separate enable output. A busy flag from a separate write engine makes the block refuse to read. A synchronous preload port fills the storage before use.

Top module: `spi_rd_seq`

## Requirements
- R1: A transaction begins when `cs_n` falls. `mosi` is sampled on each rising edge of `sck`, most significant bit first.
- R2: The read instruction byte is `0000_h_011`. Bits [7:4] are zero, bits [2:0] are 011, and bit 3 (h) is address bit 8. The next byte gives address bits 7..0, MSB first.
- R3: `miso_oe` stays low for the 16 header clocks. At the falling edge after the 16th rising edge, `miso` presents bit 7 of the addressed byte and `miso_oe` goes high.
- R4: Each later falling edge presents the next lower bit. `miso` does not change at a rising edge.
- R5: After all 8 bits of a byte have been sent, the address increments, and the next byte follows with no gap.
- R6: Address 0x1FF is followed by 0x000, so streaming continues without limit.
- R7: Raising `cs_n` ends the read at any point, including partway through a byte. `miso_oe` drops at once, and the next `cs_n` fall starts a fresh instruction.
- R8: While `wr_busy` is high, `miso_oe` is low. If `wr_busy` is seen high at any rising `sck` edge during a transaction, the block stays silent until `cs_n` rises.
- R9: For any other instruction byte, `miso_oe` stays low until `cs_n` rises.
- R10: When `pre_we` is high at a rising edge of `pre_clk`, `pre_data` is written to address `pre_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pre_clk | input | 1 | Preload clock |
| pre_we | input | 1 | Preload write enable |
| pre_addr | input | 9 | Preload address |
| pre_data | input | 8 | Preload data byte |
| cs_n | input | 1 | Chip select, active low; also the asynchronous reset of the sequencer |
| sck | input | 1 | Serial clock |
| mosi | input | 1 | Serial data in |
| wr_busy | input | 1 | High while an internal write is in progress |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for the external tri-state buffer |

## Verification
Each data bit is due at the falling `sck` edge that follows rising edge 16+n. No data bit is due at any rising edge. The bench makes `sck` edges on bench clock rising edges and samples at the next bench clock falling edge, so each sample falls half a period after the edge that should have updated the output. The bench also samples once after every rising `sck` edge, to confirm that `miso` held its value. A release of `cs_n` and a change of `wr_busy` both act without any clock, so the bench checks them at the first sample after the change. A behavioural model tracks the rising-edge count, the decoded opcode, the start address and any busy rejection, and at every sample it predicts the enable and the data bit.

// File: rtl/spi_rd_seq.sv
module spi_rd_seq #(
  parameter int ADDR_W = 9
) (
  input  logic              pre_clk,
  input  logic              pre_we,
  input  logic [ADDR_W-1:0] pre_addr,
  input  logic [7:0]        pre_data,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              mosi,
  input  logic              wr_busy,
  output logic              miso,
  output logic              miso_oe
);
  localparam int DEPTH = 1 << ADDR_W;

  typedef enum logic [1:0] {PH_OP, PH_AD, PH_DT, PH_OFF} ph_t;

  logic [7:0]        mem [DEPTH];
  ph_t               ph;
  logic [2:0]        cnt;
  logic [6:0]        sr;
  logic              hi_bit;
  logic [ADDR_W-1:0] ptr;
  logic              oe_q;
  logic              dq;

  wire [7:0] byte_in = {sr, mosi};
  wire       op_ok   = (byte_in[7:4] == 4'b0000) && (byte_in[2:0] == 3'b011);

  always_ff @(posedge pre_clk)
    if (pre_we) mem[pre_addr] <= pre_data;

  always_ff @(posedge sck or posedge cs_n) begin
    if (cs_n) begin
      ph     <= PH_OP;
      cnt    <= '0;
      sr     <= '0;
      hi_bit <= 1'b0;
      ptr    <= '0;
    end else begin
      sr  <= byte_in[6:0];
      cnt <= cnt + 3'd1;
      if (wr_busy) ph <= PH_OFF;
      else begin
        case (ph)
          PH_OP: if (cnt == 3'd7) begin
            hi_bit <= byte_in[3];
            ph     <= op_ok ? PH_AD : PH_OFF;
          end
          PH_AD: if (cnt == 3'd7) begin
            ptr <= ADDR_W'({hi_bit, byte_in});
            ph  <= PH_DT;
          end
          PH_DT: if (cnt == 3'd7) ptr <= ptr + ADDR_W'(1);
          default: ;
        endcase
      end
    end
  end

  always_ff @(negedge sck or posedge cs_n) begin
    if (cs_n) begin
      oe_q <= 1'b0;
      dq   <= 1'b0;
    end else begin
      oe_q <= (ph == PH_DT);
      dq   <= (ph == PH_DT) ? mem[ptr][3'd7 - cnt] : 1'b0;
    end
  end

  assign miso    = dq;
  assign miso_oe = oe_q & ~wr_busy;
endmodule

// File: rtl/rd_seq_chk.sv
module rd_seq_chk (
  input logic cs_n,
  input logic sck,
  input logic mosi,
  input logic wr_busy,
  input logic miso_oe
);
  logic [5:0] nrise;
  logic [6:0] sh;
  logic       good;
  logic       abort;
  wire  [7:0] opb = {sh, mosi};

  always_ff @(posedge sck or posedge cs_n) begin
    if (cs_n) begin
      nrise <= '0;
      sh    <= '0;
      good  <= 1'b0;
      abort <= 1'b0;
    end else begin
      if (nrise != 6'd63) nrise <= nrise + 6'd1;
      sh <= opb[6:0];
      if (nrise == 6'd7)
        good <= (opb[7:4] == 4'b0000) && (opb[2:0] == 3'b011);
      if (wr_busy) abort <= 1'b1;
    end
  end

  p_hdr_hiz_r3: assert property (@(negedge sck) disable iff (cs_n)
    (nrise <= 6'd16) |-> !miso_oe);

  p_busy_off_r8: assert property (@(posedge sck) disable iff (cs_n)
    wr_busy |-> !miso_oe);

  p_stream_on_r5: assert property (@(negedge sck) disable iff (cs_n)
    (nrise >= 6'd17 && good && !abort && !wr_busy) |-> miso_oe);

  p_bad_op_r9: assert property (@(negedge sck) disable iff (cs_n)
    (nrise >= 6'd9 && !good) |-> !miso_oe);
endmodule

bind spi_rd_seq rd_seq_chk u_chk (
  .cs_n(cs_n), .sck(sck), .mosi(mosi), .wr_busy(wr_busy), .miso_oe(miso_oe)
);

// File: tb/sim_spi_rd_seq.sv
`timescale 1ns/1ps
module sim_spi_rd_seq;
  logic       clk = 1'b0;
  logic       pre_we = 1'b0;
  logic [8:0] pre_addr = '0;
  logic [7:0] pre_data = '0;
  logic       cs_n, sck, mosi, wr_busy;
  logic       miso, miso_oe;

  always #5 clk = ~clk;

  spi_rd_seq #(.ADDR_W(9)) u0 (
    .pre_clk(clk), .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data),
    .cs_n(cs_n), .sck(sck), .mosi(mosi), .wr_busy(wr_busy),
    .miso(miso), .miso_oe(miso_oe)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] ref_mem [512];
  string req = "R1";

  int         k;
  logic [7:0] opsh;
  logic       op_valid, aborted, a8;
  logic [7:0] alo;
  int         base;
  logic       exp_oe, exp_bit;

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 29 + 7) ^ (i >> 3));
  endfunction

  task automatic chk(input string r, input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b (rise %0d)", r, what, act, exp, k);
    end
  endtask

  task automatic model_out();
    int idx;
    int a;
    exp_oe = op_valid && !aborted && (k >= 16) && !wr_busy;
    exp_bit = 1'b0;
    if (exp_oe) begin
      idx = k - 16;
      a = (base + idx / 8) % 512;
      exp_bit = ref_mem[a][7 - idx % 8];
    end
  endtask

  task automatic start();
    @(negedge clk);
    cs_n = 1'b0;
    k = 0; opsh = '0; op_valid = 1'b0; aborted = 1'b0; a8 = 1'b0; alo = '0; base = 0;
  endtask

  task automatic stop_chk();
    @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
    chk("R7", miso_oe, 1'b0, "oe after cs release");
  endtask

  task automatic bitx(input logic b);
    logic held_oe, held_bit;
    @(negedge clk);
    mosi = b;
    model_out();
    held_oe = exp_oe;
    held_bit = exp_bit;
    @(posedge clk);
    sck = 1'b1;
    k++;
    if (wr_busy) aborted = 1'b1;
    opsh = {opsh[6:0], b};
    if (k == 8) begin
      op_valid = (opsh[7:4] == 4'b0000) && (opsh[2:0] == 3'b011);
      a8 = opsh[3];
    end
    if (k > 8 && k <= 16) alo = {alo[6:0], b};
    if (k == 16) base = {23'b0, a8, alo};
    @(negedge clk);
    if (held_oe && !wr_busy && !aborted)
      chk("R4", miso, held_bit, "miso moved at rising edge");
    @(posedge clk);
    sck = 1'b0;
    @(negedge clk);
    model_out();
    chk(req, miso_oe, exp_oe, "miso_oe");
    if (exp_oe) chk(req, miso, exp_bit, "miso data");
  endtask

  task automatic sbyte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) bitx(v[i]);
  endtask

  task automatic dclk(input int n);
    for (int i = 0; i < n; i++) bitx(1'b0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    cs_n = 1'b0; sck = 1'b0; mosi = 1'b0; wr_busy = 1'b0; k = 0;
    #2 cs_n = 1'b1;
    for (int i = 0; i < 512; i++) begin
      @(negedge clk);
      pre_we = 1'b1; pre_addr = 9'(i); pre_data = pat(i);
      ref_mem[i] = pat(i);
    end
    @(negedge clk);
    pre_we = 1'b0;
    @(negedge clk);
    chk("R7", miso_oe, 1'b0, "reset state oe");

    req = "R3";
    start(); sbyte(8'h03); sbyte(8'h05); dclk(24); stop_chk();

    req = "R2";
    start(); sbyte(8'h0B); sbyte(8'h10); dclk(16); stop_chk();

    req = "R10";
    start(); sbyte(8'h03); sbyte(8'h80); dclk(8); stop_chk();

    req = "R6";
    start(); sbyte(8'h0B); sbyte(8'hFE); dclk(32); stop_chk();

    req = "R5";
    start(); sbyte(8'h03); sbyte(8'hFF); dclk(16); stop_chk();

    req = "R7";
    start(); sbyte(8'h03); sbyte(8'h40); dclk(4); stop_chk();
    req = "R1";
    start(); sbyte(8'h03); sbyte(8'h41); dclk(8); stop_chk();

    req = "R9";
    start(); sbyte(8'h13); sbyte(8'h05); dclk(16); stop_chk();
    start(); sbyte(8'h02); sbyte(8'h05); dclk(16); stop_chk();
    start(); sbyte(8'h83); sbyte(8'h05); dclk(16); stop_chk();

    req = "R8";
    start();
    @(negedge clk); wr_busy = 1'b1;
    bitx(1'b0); bitx(1'b0); bitx(1'b0);
    @(negedge clk); wr_busy = 1'b0;
    bitx(1'b0); bitx(1'b0); bitx(1'b0); bitx(1'b1); bitx(1'b1);
    sbyte(8'h20); dclk(16); stop_chk();

    start(); sbyte(8'h03); sbyte(8'h60); dclk(12);
    @(negedge clk); wr_busy = 1'b1;
    @(negedge clk);
    chk("R8", miso_oe, 1'b0, "oe while busy, no clock");
    dclk(2);
    @(negedge clk); wr_busy = 1'b0;
    dclk(8); stop_chk();

    req = "R1";
    start(); sbyte(8'h03); sbyte(8'h61); dclk(8); stop_chk();

    finish_run();
  end
endmodule